// File: doc/BRIEF.md
# Enqueue Credit Pool Manager

This block holds the enqueue credits of one scheduling domain. It keeps two independent counters: one for traffic bound to load-balanced queues and one for traffic bound to directed queues. A producer port presents an enqueue request tagged with the queue kind. The block grants the request in the same cycle only when the matching counter is above zero, and the grant costs one credit. A request that finds its pool empty is turned away. Turning requests away is the only means by which the queue storage further down the path is kept from overflowing.

When an element leaves a consumer queue, a dequeue event tagged with the kind returns one credit to the matching pool. A grant and a return can land on the same pool in the same cycle. Pool sizes come from two configuration inputs. They are captured while reset is held and again on each cycle the load strobe is high. Each pool keeps its own sticky flag, which records a return that found the pool already full.

Top module: `cpm_credit_mgr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, each pool level and each pool limit take the (clamped) size input of that pool, and both overflow flags clear.
- R2: `enq_accept` is high in the same cycle exactly when `enq_valid` is high, `cfg_load` is low and the pool chosen by `enq_is_dir` holds a nonzero level.
- R3: An accepted enqueue lowers the chosen pool by one at the next clock edge and leaves the other pool unchanged, unless a return to the same pool coincides with it.
- R4: A rejected enqueue changes neither pool level.
- R5: A dequeue event on a pool below its limit raises that pool by one at the next clock edge.
- R6: An accepted enqueue and a dequeue event aimed at the same pool in one cycle leave that pool's level unchanged, and no overflow is flagged.
- R7: A dequeue event on a pool already at its limit, with no accepted enqueue to that pool in the same cycle, is dropped. It sets that pool's overflow flag, which stays high until the next load or reset.
- R8: A cycle with `cfg_load` high reloads both levels and both limits from the size inputs and clears both flags. In that cycle every enqueue is refused and every dequeue event is ignored.
- R9: A size input above the pool maximum (8192 load-balanced, 2048 directed by default) is taken as that maximum. No level ever exceeds its maximum.
- R10: The kind bit selects the pool, for enqueues (`enq_is_dir`) and for dequeue events (`deq_is_dir`) alike. The value 0 selects the load-balanced pool and 1 selects the directed pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the sizes |
| cfg_load | input | 1 | Strobe that reloads both pools from the size inputs |
| cfg_lb_size | input | LB_W (14) | Load-balanced pool size |
| cfg_dir_size | input | DIR_W (12) | Directed pool size |
| enq_valid | input | 1 | Enqueue request present |
| enq_is_dir | input | 1 | Kind of the enqueue target: 0 load-balanced, 1 directed |
| enq_accept | output | 1 | Request granted this cycle; one credit is spent |
| deq_valid | input | 1 | Consumer dequeue event present |
| deq_is_dir | input | 1 | Kind of the dequeued element: 0 load-balanced, 1 directed |
| lb_level | output | LB_W (14) | Current load-balanced credit count |
| dir_level | output | DIR_W (12) | Current directed credit count |
| lb_ovf | output | 1 | Sticky flag: a load-balanced return found the pool full |
| dir_ovf | output | 1 | Sticky flag: a directed return found the pool full |

## Verification
The properties assume that the kind bits are driven to known values whenever their valid bits are high. They also assume that the size inputs stay steady across the cycle in which they are sampled. The bench changes every input only on the falling edge, and it changes the sizes only in the cycle before a load or a reset. Returns past the limit are driven on purpose, because the overflow behaviour is itself a requirement. The properties therefore bound the levels by the maximums and never assume that returns are well-behaved.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;
   // Pool index, also the value of the kind bit that selects it
   typedef enum logic {
      POOL_LB  = 1'b0,
      POOL_DIR = 1'b1
   } pool_e;

   localparam int NUM_POOLS = 2;
endpackage

// File: rtl/cpm_pool.sv
`timescale 1ns/1ps
// One credit counter with its limit and sticky overflow flag.
module cpm_pool #(
   parameter int W          = 14,
   parameter int MAX        = 8192,
   parameter bit SIZE_CLAMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] size,
   input  logic         spend,
   input  logic         refill,
   output logic         grant,
   output logic [W-1:0] level,
   output logic         ovf
);
   localparam logic [W-1:0] MAX_V = W'(MAX);

   generate
      if (MAX >= (2 ** W)) begin : g_bad_width
         $error("cpm_pool: W too narrow for MAX");
      end
      if (MAX < 1) begin : g_bad_max
         $error("cpm_pool: MAX must be positive");
      end
   endgenerate

   logic [W-1:0] size_eff;
   logic [W-1:0] level_q;
   logic [W-1:0] limit_q;
   logic         ovf_q;

   generate
      if (SIZE_CLAMP) begin : g_clamp
         assign size_eff = (size > MAX_V) ? MAX_V : size;
      end else begin : g_pass
         assign size_eff = size;
      end
   endgenerate

   logic at_top;
   logic refill_take;
   logic refill_drop;

   assign grant       = spend & ~load & (level_q != '0);
   assign at_top      = (level_q >= limit_q);
   assign refill_take = refill & ~load & ~grant & ~at_top;
   assign refill_drop = refill & ~load & ~grant & at_top;

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         level_q <= size_eff;
         limit_q <= size_eff;
         ovf_q   <= 1'b0;
      end else begin
         if (grant && !refill) begin
            level_q <= level_q - 1'b1;
         end else if (refill_take) begin
            level_q <= level_q + 1'b1;
         end
         if (refill_drop) begin
            ovf_q <= 1'b1;
         end
      end
   end

   assign level = level_q;
   assign ovf   = ovf_q;
endmodule

// File: rtl/cpm_route.sv
`timescale 1ns/1ps
// Steers enqueue requests and dequeue returns to the pool named by the kind bit.
module cpm_route
   import cpm_pkg::*;
(
   input  logic                 enq_valid,
   input  logic                 enq_is_dir,
   input  logic                 deq_valid,
   input  logic                 deq_is_dir,
   input  logic [NUM_POOLS-1:0] grant,
   output logic [NUM_POOLS-1:0] spend,
   output logic [NUM_POOLS-1:0] refill,
   output logic                 enq_accept
);
   generate
      for (genvar k = 0; k < NUM_POOLS; k++) begin : g_sel
         localparam logic KIND = k[0];
         assign spend[k]  = enq_valid & (enq_is_dir == KIND);
         assign refill[k] = deq_valid & (deq_is_dir == KIND);
      end
   endgenerate

   assign enq_accept = |grant;
endmodule

// File: rtl/cpm_credit_mgr.sv
`timescale 1ns/1ps
module cpm_credit_mgr
   import cpm_pkg::*;
#(
   parameter int LB_MAX     = 8192,
   parameter int DIR_MAX    = 2048,
   parameter int LB_W       = 14,
   parameter int DIR_W      = 12,
   parameter bit SIZE_CLAMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [LB_W-1:0]  cfg_lb_size,
   input  logic [DIR_W-1:0] cfg_dir_size,
   input  logic             enq_valid,
   input  logic             enq_is_dir,
   output logic             enq_accept,
   input  logic             deq_valid,
   input  logic             deq_is_dir,
   output logic [LB_W-1:0]  lb_level,
   output logic [DIR_W-1:0] dir_level,
   output logic             lb_ovf,
   output logic             dir_ovf
);
   logic [NUM_POOLS-1:0] spend;
   logic [NUM_POOLS-1:0] refill;
   logic [NUM_POOLS-1:0] grant;

   cpm_route u_route (
      .enq_valid  (enq_valid),
      .enq_is_dir (enq_is_dir),
      .deq_valid  (deq_valid),
      .deq_is_dir (deq_is_dir),
      .grant      (grant),
      .spend      (spend),
      .refill     (refill),
      .enq_accept (enq_accept)
   );

   cpm_pool #(.W(LB_W), .MAX(LB_MAX), .SIZE_CLAMP(SIZE_CLAMP)) u_lb_pool (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cfg_load),
      .size   (cfg_lb_size),
      .spend  (spend[POOL_LB]),
      .refill (refill[POOL_LB]),
      .grant  (grant[POOL_LB]),
      .level  (lb_level),
      .ovf    (lb_ovf)
   );

   cpm_pool #(.W(DIR_W), .MAX(DIR_MAX), .SIZE_CLAMP(SIZE_CLAMP)) u_dir_pool (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cfg_load),
      .size   (cfg_dir_size),
      .spend  (spend[POOL_DIR]),
      .refill (refill[POOL_DIR]),
      .grant  (grant[POOL_DIR]),
      .level  (dir_level),
      .ovf    (dir_ovf)
   );
endmodule

// File: rtl/cpm_credit_chk.sv
`timescale 1ns/1ps
module cpm_credit_chk #(
   parameter int LB_MAX  = 8192,
   parameter int DIR_MAX = 2048,
   parameter int LB_W    = 14,
   parameter int DIR_W   = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_load,
   input logic [LB_W-1:0]  cfg_lb_size,
   input logic [DIR_W-1:0] cfg_dir_size,
   input logic             enq_valid,
   input logic             enq_is_dir,
   input logic             enq_accept,
   input logic             deq_valid,
   input logic             deq_is_dir,
   input logic [LB_W-1:0]  lb_level,
   input logic [DIR_W-1:0] dir_level,
   input logic             lb_ovf,
   input logic             dir_ovf
);
   localparam logic [DIR_W-1:0] DIR_CAP = DIR_W'(DIR_MAX);
   localparam logic [LB_W-1:0]  LB_CAP  = LB_W'(LB_MAX);

   // R2
   empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_is_dir && lb_level == '0) |-> !enq_accept);

   // R8
   load_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> !enq_accept);

   // R3
   lb_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_accept && !enq_is_dir && !(deq_valid && !deq_is_dir))
      |=> ((lb_level + 1'b1) == $past(lb_level)));

   // R6
   dir_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_accept && enq_is_dir && deq_valid && deq_is_dir) |=> $stable(dir_level));

   // R7
   lb_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_ovf && !cfg_load) |=> lb_ovf);

   // R9
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_level <= LB_CAP) && (dir_level <= DIR_CAP));

   // R8
   dir_load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (dir_level == (($past(cfg_dir_size) > DIR_CAP) ? DIR_CAP : $past(cfg_dir_size)))
                   && !dir_ovf);
endmodule

bind cpm_credit_mgr cpm_credit_chk #(
   .LB_MAX(LB_MAX), .DIR_MAX(DIR_MAX), .LB_W(LB_W), .DIR_W(DIR_W)
) i_cpm_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_load     (cfg_load),
   .cfg_lb_size  (cfg_lb_size),
   .cfg_dir_size (cfg_dir_size),
   .enq_valid    (enq_valid),
   .enq_is_dir   (enq_is_dir),
   .enq_accept   (enq_accept),
   .deq_valid    (deq_valid),
   .deq_is_dir   (deq_is_dir),
   .lb_level     (lb_level),
   .dir_level    (dir_level),
   .lb_ovf       (lb_ovf),
   .dir_ovf      (dir_ovf)
);

// File: tb/test_cpm_credit_mgr.sv
`timescale 1ns/1ps
module test_cpm_credit_mgr;
   localparam int LB_MAX  = 8192;
   localparam int DIR_MAX = 2048;
   localparam int LB_W    = 14;
   localparam int DIR_W   = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_load = 1'b0;
   logic [LB_W-1:0]  cfg_lb_size = '0;
   logic [DIR_W-1:0] cfg_dir_size = '0;
   logic             enq_valid = 1'b0;
   logic             enq_is_dir = 1'b0;
   logic             enq_accept;
   logic             deq_valid = 1'b0;
   logic             deq_is_dir = 1'b0;
   logic [LB_W-1:0]  lb_level;
   logic [DIR_W-1:0] dir_level;
   logic             lb_ovf;
   logic             dir_ovf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // model state
   int m_lb, m_dir, m_lb_lim, m_dir_lim;
   bit m_lb_ovf, m_dir_ovf;

   // scoreboard queues
   int    q_lb[$];
   int    q_dir[$];
   bit    q_olb[$];
   bit    q_odir[$];
   string q_tag[$];

   always #2.5 clk = ~clk;

   cpm_credit_mgr #(.LB_MAX(LB_MAX), .DIR_MAX(DIR_MAX), .LB_W(LB_W), .DIR_W(DIR_W)) i_cpm_credit_mgr (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_lb_size(cfg_lb_size), .cfg_dir_size(cfg_dir_size),
      .enq_valid(enq_valid), .enq_is_dir(enq_is_dir), .enq_accept(enq_accept),
      .deq_valid(deq_valid), .deq_is_dir(deq_is_dir),
      .lb_level(lb_level), .dir_level(dir_level), .lb_ovf(lb_ovf), .dir_ovf(dir_ovf)
   );

   function automatic int clamp(int v, int mx);
      return (v > mx) ? mx : v;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_load();
      m_lb      = clamp(int'(cfg_lb_size), LB_MAX);
      m_dir     = clamp(int'(cfg_dir_size), DIR_MAX);
      m_lb_lim  = m_lb;
      m_dir_lim = m_dir;
      m_lb_ovf  = 1'b0;
      m_dir_ovf = 1'b0;
   endtask

   task automatic pool_step(inout int lvl, input int lim, inout bit ovf, input bit sp, input bit rf);
      if (sp && rf) begin
      end else if (sp) begin
         lvl--;
      end else if (rf) begin
         if (lvl < lim) lvl++;
         else ovf = 1'b1;
      end
   endtask

   // driver: one cycle of stimulus, accept check, expected levels queued
   task automatic step(bit ev, bit ed, bit dv, bit dd, bit ld, string tag);
      bit acc;
      @(negedge clk);
      enq_valid  = ev;
      enq_is_dir = ed;
      deq_valid  = dv;
      deq_is_dir = dd;
      cfg_load   = ld;
      #1;
      acc = ev && !ld && (ed ? (m_dir != 0) : (m_lb != 0));
      chk(enq_accept == acc, tag, "enq_accept", int'(enq_accept), int'(acc));
      if (ld) begin
         model_load();
      end else begin
         pool_step(m_lb,  m_lb_lim,  m_lb_ovf,  acc && !ed, dv && !dd);
         pool_step(m_dir, m_dir_lim, m_dir_ovf, acc && ed,  dv && dd);
      end
      q_lb.push_back(m_lb);
      q_dir.push_back(m_dir);
      q_olb.push_back(m_lb_ovf);
      q_odir.push_back(m_dir_ovf);
      q_tag.push_back(tag);
   endtask

   // monitor: compares levels after the edge that follows each driven cycle
   always @(posedge clk) begin
      #1;
      if (q_tag.size() != 0) begin
         int    e_lb, e_dir;
         bit    e_olb, e_odir;
         string t;
         e_lb   = q_lb.pop_front();
         e_dir  = q_dir.pop_front();
         e_olb  = q_olb.pop_front();
         e_odir = q_odir.pop_front();
         t      = q_tag.pop_front();
         chk(int'(lb_level) == e_lb,   t, "lb_level",  int'(lb_level),  e_lb);
         chk(int'(dir_level) == e_dir, t, "dir_level", int'(dir_level), e_dir);
         chk(lb_ovf == e_olb,   t, "lb_ovf",  int'(lb_ovf),  int'(e_olb));
         chk(dir_ovf == e_odir, t, "dir_ovf", int'(dir_ovf), int'(e_odir));
      end
   end

   task automatic do_reset(int lbs, int dirs, string tag);
      @(negedge clk);
      enq_valid    = 1'b0;
      deq_valid    = 1'b0;
      cfg_load     = 1'b0;
      cfg_lb_size  = LB_W'(lbs);
      cfg_dir_size = DIR_W'(dirs);
      rst_n        = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_load();
      #1;
      chk(int'(lb_level) == m_lb,   tag, "reset lb_level",  int'(lb_level),  m_lb);
      chk(int'(dir_level) == m_dir, tag, "reset dir_level", int'(dir_level), m_dir);
      chk(!lb_ovf && !dir_ovf, tag, "reset ovf flags", int'({lb_ovf, dir_ovf}), 0);
   endtask

   initial begin
      // R1
      do_reset(3, 2, "R1");
      // R3 drain the load-balanced pool
      step(1, 0, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 0, "R3");
      // R4 / R2: empty pool rejects
      step(1, 0, 0, 0, 0, "R4");
      // R10 directed request is served from its own pool
      step(1, 1, 0, 0, 0, "R10");
      // R5 load-balanced return
      step(0, 0, 1, 0, 0, "R5");
      // R6 directed spend and return together
      step(1, 1, 1, 1, 0, "R6");
      step(0, 0, 1, 1, 0, "R5");
      // R7 return at limit dropped, flag sticks
      step(0, 0, 1, 1, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      step(1, 0, 1, 0, 0, "R6");
      // R8 / R9 load with oversize values; enqueue refused
      @(negedge clk);
      cfg_lb_size  = LB_W'(9000);
      cfg_dir_size = DIR_W'(3000);
      step(1, 0, 1, 1, 1, "R9");
      step(0, 0, 1, 0, 0, "R7");
      @(negedge clk);
      cfg_lb_size  = LB_W'(5);
      cfg_dir_size = DIR_W'(0);
      step(1, 1, 0, 0, 1, "R8");
      step(1, 1, 0, 0, 0, "R2");
      step(1, 0, 0, 1, 0, "R10");
      step(0, 0, 1, 0, 0, "R5");
      // R1 / R9 reset with oversize sizes
      @(negedge clk);
      @(negedge clk);
      do_reset(16000, 4000, "R9");
      step(1, 0, 0, 0, 0, "R3");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule